// File: doc/BRIEF.md
# Counting-Ramp Conversion Controller

This block is the digital half of a ramp-type analog-to-digital converter. A one-cycle start request freezes the external sample-and-hold stage and clears a code counter. The counter value goes straight out to an external DAC, and an external comparator reports whether the DAC level is still below the held input. While that report stays high the counter steps up one code per clock. When the report drops, or the counter reaches its top code, counting halts, the count is captured as the conversion result and a done flag is raised.

A conversion therefore takes a number of clocks that depends on the input level: roughly one clock per code plus one. The done flag and the captured result persist until software or a sequencer issues the next start. The hold output covers the whole conversion, including the cycle in which done rises, and is released one clock later. The converter, comparator and hold capacitor themselves sit outside this block.

Top module: `ramp_adc`

## Requirements
- R1: Synchronous active-high reset clears the counter (dacCode = 0), the captured result (0), busy and done, and drives holdEn low.
- R2: A startPulse sampled while busy is low makes busy = 1, holdEn = 1, done = 0 and dacCode = 0 on the following clock.
- R3: While busy and cmpBelow = 1 and dacCode is below the top code 0xFFF, dacCode increases by exactly one per clock.
- R4: When cmpBelow = 0 is sampled while busy, the next clock shows busy = 0, done = 1, and result equal to the dacCode at the sampled edge; dacCode stops changing.
- R5: With an ideal comparator (cmpBelow = 1 when dacCode is below the input code V), done is first seen V + 1 clocks after the start edge.
- R6: If the comparator never trips, counting stops at 0xFFF, which is reported as result with done = 1 (4096 clocks after the start edge).
- R7: A startPulse sampled while busy = 1 is ignored: the count continues and the result and latency equal those of an undisturbed conversion.
- R8: holdEn stays 1 from the clock after start through the clock in which done rises, and goes to 0 on the next clock unless a new start is accepted.
- R9: done and result keep their values until the next accepted start; that start clears done but result keeps the previous value until the new conversion ends.
- R10: An input of code 0 (cmpBelow = 0 at once) gives result 0 with done on the first clock after the start edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| startPulse | input | 1 | One-cycle request to start a conversion |
| cmpBelow | input | 1 | Comparator: 1 while the DAC level is below the held input |
| dacCode | output | 12 | Current counter value driving the external DAC |
| holdEn | output | 1 | 1 = sample-and-hold keeps the input frozen |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | Conversion finished; result is valid |
| result | output | 12 | Captured conversion code |

## Verification
The bench targets the three ends of the code range: an input of zero, where a design that checks the comparator one cycle late would report code 1; a mid-range value, whose exact clock count exposes an off-by-one in the stop condition; and an input above full scale, where a counter without a top stop would wrap to zero and keep running. It also fires a start in the middle of a conversion, which a design lacking the busy guard would answer by restarting the count and returning a late, wrong latency. Finally it watches the hold line around the done edge and the persistence of done and result across idle cycles and into the next conversion, where early release or an early cleared result shows up directly.

// File: rtl/ramp_adc_pkg.sv
package ramp_adc_pkg;

  // Strobes issued by the control each clock to the datapath
  typedef struct packed {
    logic clearCount;   // reset counter to zero (accepted start)
    logic stepCount;    // advance counter by one code
    logic latchResult;  // capture counter into result register
  } rampStrobes_t;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_COUNT   = 2'd1,
    ST_RELEASE = 2'd2
  } rampState_t;

endpackage

// File: rtl/ramp_adc_ctrl.sv
module ramp_adc_ctrl
  import ramp_adc_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         startPulse,
  input  logic         cmpBelow,
  input  logic         atTop,
  output rampStrobes_t strobes,
  output logic         busy,
  output logic         done,
  output logic         holdEn
);

  rampState_t state, stateNext;
  logic       startOk;
  logic       endNow;
  logic       doneReg;
  logic       holdReg;

  assign startOk = startPulse && (state != ST_COUNT);
  assign endNow  = (state == ST_COUNT) && (!cmpBelow || atTop);

  always_comb begin
    strobes             = '0;
    strobes.clearCount  = startOk;
    strobes.stepCount   = (state == ST_COUNT) && cmpBelow && !atTop;
    strobes.latchResult = endNow;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:    if (startOk) stateNext = ST_COUNT;
      ST_COUNT:   if (endNow)  stateNext = ST_RELEASE;
      ST_RELEASE: stateNext = startOk ? ST_COUNT : ST_IDLE;
      default:    stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      doneReg <= 1'b0;
      holdReg <= 1'b0;
    end else begin
      state <= stateNext;
      if (startOk)
        doneReg <= 1'b0;
      else if (endNow)
        doneReg <= 1'b1;
      if (startOk)
        holdReg <= 1'b1;
      else if (state == ST_RELEASE)
        holdReg <= 1'b0;
    end
  end

  assign busy   = (state == ST_COUNT);
  assign done   = doneReg;
  assign holdEn = holdReg;

endmodule

// File: rtl/ramp_adc_datapath.sv
module ramp_adc_datapath
  import ramp_adc_pkg::*;
#(
  parameter int CODE_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  rampStrobes_t      strobes,
  output logic [CODE_W-1:0] countVal,
  output logic [CODE_W-1:0] resultVal,
  output logic              atTop
);

  localparam logic [CODE_W-1:0] TOP_CODE = {CODE_W{1'b1}};
  localparam logic [CODE_W-1:0] ONE_CODE = {{(CODE_W-1){1'b0}}, 1'b1};

  logic [CODE_W-1:0] countReg;
  logic [CODE_W-1:0] resultReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      countReg <= '0;
    end else if (strobes.clearCount) begin
      countReg <= '0;
    end else if (strobes.stepCount) begin
      countReg <= countReg + ONE_CODE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      resultReg <= '0;
    end else if (strobes.latchResult) begin
      resultReg <= countReg;
    end
  end

  assign atTop     = (countReg == TOP_CODE);
  assign countVal  = countReg;
  assign resultVal = resultReg;

endmodule

// File: rtl/ramp_adc.sv
module ramp_adc
  import ramp_adc_pkg::*;
#(
  parameter int CODE_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              startPulse,
  input  logic              cmpBelow,
  output logic [CODE_W-1:0] dacCode,
  output logic              holdEn,
  output logic              busy,
  output logic              done,
  output logic [CODE_W-1:0] result
);

  rampStrobes_t strobes;
  logic         atTop;

  ramp_adc_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .startPulse (startPulse),
    .cmpBelow   (cmpBelow),
    .atTop      (atTop),
    .strobes    (strobes),
    .busy       (busy),
    .done       (done),
    .holdEn     (holdEn)
  );

  ramp_adc_datapath #(.CODE_W(CODE_W)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .strobes   (strobes),
    .countVal  (dacCode),
    .resultVal (result),
    .atTop     (atTop)
  );

endmodule

// File: rtl/ramp_adc_checker.sv
module ramp_adc_checker #(
  parameter int CODE_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              startPulse,
  input logic              cmpBelow,
  input logic [CODE_W-1:0] dacCode,
  input logic              holdEn,
  input logic              busy,
  input logic              done,
  input logic [CODE_W-1:0] result
);

  localparam logic [CODE_W-1:0] TOP_CODE = {CODE_W{1'b1}};

  AST_START_BEGINS: assert property (@(posedge clk) disable iff (rst)
    (startPulse && !busy) |=> (busy && holdEn && !done && dacCode == '0)); // R2

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (busy && cmpBelow && dacCode != TOP_CODE) |=> (dacCode == $past(dacCode) + 1'b1)); // R3

  AST_TRIP_LATCH: assert property (@(posedge clk) disable iff (rst)
    (busy && !cmpBelow) |=> (done && !busy && result == $past(dacCode))); // R4

  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(busy && done)); // R4

  AST_TOP_STOP: assert property (@(posedge clk) disable iff (rst)
    (busy && dacCode == TOP_CODE) |=> (done && result == TOP_CODE)); // R6

  AST_HOLD_DURING: assert property (@(posedge clk) disable iff (rst)
    busy |-> holdEn); // R8

  AST_HOLD_RELEASE: assert property (@(posedge clk) disable iff (rst)
    ($rose(done) && !startPulse) |=> !holdEn); // R8

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    (done && !startPulse) |=> done); // R9

  AST_RESULT_STABLE: assert property (@(posedge clk) disable iff (rst)
    !$rose(done) |-> $stable(result)); // R9

endmodule

bind ramp_adc ramp_adc_checker #(.CODE_W(CODE_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .startPulse (startPulse),
  .cmpBelow   (cmpBelow),
  .dacCode    (dacCode),
  .holdEn     (holdEn),
  .busy       (busy),
  .done       (done),
  .result     (result)
);

// File: tb/ramp_adc_tb.sv
`timescale 1ns/1ps
module ramp_adc_tb;

  localparam int CODE_W = 12;

  logic              clk = 1'b0;
  logic              rst;
  logic              startPulse;
  logic              cmpBelow;
  logic [CODE_W-1:0] dacCode;
  logic              holdEn;
  logic              busy;
  logic              done;
  logic [CODE_W-1:0] result;

  int vin;          // ideal held input code (may exceed full scale)
  int errors = 0;
  int checks = 0;
  int cycleCount = 0;
  int lastResult = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cycleCount <= cycleCount + 1;

  assign cmpBelow = (int'(dacCode) < vin);

  ramp_adc #(.CODE_W(CODE_W)) u_dut (
    .clk        (clk),
    .rst        (rst),
    .startPulse (startPulse),
    .cmpBelow   (cmpBelow),
    .dacCode    (dacCode),
    .holdEn     (holdEn),
    .busy       (busy),
    .done       (done),
    .result     (result)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // R1
  task automatic t_reset();
    rst = 1'b1; startPulse = 1'b0; vin = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1", "busy", busy, 0);
    check("R1", "done", done, 0);
    check("R1", "holdEn", holdEn, 0);
    check("R1", "dacCode", dacCode, 0);
    check("R1", "result", result, 0);
  endtask

  // One conversion; glitchAt > 0 pulses start that many clocks into the count
  task automatic t_convert(input int v, input int glitchAt, input string tag);
    int expCode;
    int k;
    bit stepErr;
    expCode = (v > 4095) ? 4095 : v;
    vin = v;
    @(negedge clk);
    startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    check("R2", "busy after start", busy, (expCode == 0 && v == 0) ? 1 : 1);
    check("R2", "holdEn after start", holdEn, 1);
    check("R2", "dacCode after start", dacCode, 0);
    check("R9", "done cleared by start", done, 0);
    check("R9", "result kept into new conversion", result, lastResult);
    k = 0;
    stepErr = 0;
    while (!done && k < 5000) begin
      if (busy && dacCode != k) stepErr = 1;
      if (!holdEn) stepErr = 1;
      if (glitchAt > 0 && k == glitchAt) startPulse = 1'b1;
      @(negedge clk);
      startPulse = 1'b0;
      k++;
    end
    check("R3", {tag, " step-by-one and hold during count"}, stepErr, 0);
    check("R5", {tag, " clocks to done"}, k, expCode + 1);
    check("R4", {tag, " result"}, result, expCode);
    check("R4", {tag, " busy cleared"}, busy, 0);
    check("R8", {tag, " hold in done cycle"}, holdEn, 1);
    @(negedge clk);
    check("R8", {tag, " hold released"}, holdEn, 0);
    check("R4", {tag, " dacCode frozen"}, dacCode, expCode);
    lastResult = expCode;
  endtask

  // R9: done and result persist while idle; input change has no effect
  task automatic t_sticky();
    vin = 17;
    repeat (12) @(negedge clk);
    check("R9", "done held idle", done, 1);
    check("R9", "result held idle", result, lastResult);
    check("R9", "busy idle", busy, 0);
  endtask

  initial begin
    t_reset();
    t_convert(0, 0, "zero R10");
    t_convert(300, 0, "mid");
    t_sticky();
    t_convert(50, 0, "low");
    t_convert(200, 60, "busy-start R7");
    t_convert(5000, 0, "overrange R6");
    t_convert(4095, 0, "fullscale R6");
    t_sticky();
    finish_run();
  end

  initial begin
    wait (cycleCount > 150000);
    errors++;
    $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cycleCount);
    finish_run();
  end

endmodule